// File: doc/BRIEF.md
# HDLC Host Register Interface

This block sits between a host bus master and a serial HDLC frame engine. It is a slave with a classic cycle/strobe handshake. A 3-bit address selects one of five registers. Frame payload moves across the 32-bit data bus as packed words of four octets. The lowest-numbered octet of each word sits in the least significant byte lane. Two tag outputs let the host poll, or take an interrupt, for "transmit buffer can take data" and "received frame waiting".

To transmit, the host writes payload words into the transmit buffer and then writes the go code 0x22 to transmit control. The frame engine then reads the frame one octet at a time through a small streaming port and signals when the frame has gone out.

On the receive side, the frame engine pushes octets and marks the end of the frame. The host then reads the frame size and reads the buffer in a burst. Finally it reads receive control, which hands the buffer back to the engine for the next frame.

Top module: `hdlc_host_regs`

## Requirements
- R1: After reset ack_o, rty_o and tx_start_o are low, tag0_o is high, tag1_o is low, and the frame size register (address 4) reads 0.
- R2: A request (cyc_i and stb_i high) is answered by exactly one of ack_o or rty_o, one cycle after it is taken. While the request is held, answers come every second cycle. ack_o and rty_o are never high together.
- R3: Transmit buffer words are written at address 1. Octet k of the outgoing frame is bits [8*(k%4)+7 : 8*(k%4)] of word k/4. tx_oct_o shows the current octet, and each cycle with tx_oct_rd_i high advances to the next one.
- R4: Writing exactly 0x22 in bits 7:0 of address 0, while idle with at least one buffered word, pulses tx_start_o for one cycle with tx_len_o equal to 4 times the buffered word count, and drops tag0_o. Any other value, or an empty buffer, starts nothing.
- R5: A write to address 1 while a transmission is in progress is answered with rty_o instead of ack_o, and the buffer contents and length are left unchanged.
- R6: tag0_o is low while the transmit buffer holds TX_WORDS words. Further writes are acknowledged and dropped. tx_done_i ends the transmission, empties the buffer and raises tag0_o.
- R7: Received octet k is stored in byte lane k%4 of word k/4, and unfilled lanes of the last word read as 0. rx_end_i raises tag1_o on the next cycle.
- R8: Address 4 returns the received octet count in bits 7:0, with zeros above.
- R9: Successive reads of address 3 return successive receive words. Once the words holding the frame are used up, reads return 0 and the read position stays put.
- R10: A read of address 2 returns the frame-ready flag in bit 0. It also clears tag1_o, rewinds the receive read position to word 0 and resets the octet count to 0.
- R11: While tag1_o is high, incoming octets and rx_end_i are ignored.
- R12: Address 0 reads back transmit busy in bit 0 and tag0_o in bit 1. Addresses 5 to 7 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | 3 | Register select |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | Access completed |
| rty_o | output | 1 | Access refused, try again |
| tag0_o | output | 1 | Transmit buffer can accept data |
| tag1_o | output | 1 | Received frame ready |
| tx_start_o | output | 1 | One-cycle pulse: frame engine may start sending |
| tx_len_o | output | 6 | Transmit frame length in octets |
| tx_oct_o | output | 8 | Current transmit octet |
| tx_oct_rd_i | input | 1 | Frame engine consumed tx_oct_o |
| tx_done_i | input | 1 | Frame engine finished the frame |
| rx_oct_wr_i | input | 1 | Received octet valid |
| rx_oct_i | input | 8 | Received octet |
| rx_end_i | input | 1 | Received frame complete |

## Verification
A bad octet pointer or byte-lane select shows at once as a wrong tx_oct_o during the drain, or as a wrong packed word on the next receive-buffer read. The scoreboard compares every read and every octet against values it computes itself.

A stuck busy or ready flag shows within one cycle as a wrong tag, and within one access as an ack where a retry belonged, or the reverse. A read pointer that is not rewound, or that runs past the frame, shows on the first burst word after a release, or as a non-zero word past the frame end.

// File: rtl/hdlc_host_pkg.sv
package hdlc_host_pkg;
   localparam int OCT_W = 8;
   localparam logic [7:0] TX_GO_CODE = 8'h22;

   typedef enum logic [2:0] {
      SEL_TXCTL = 3'd0,
      SEL_TXBUF = 3'd1,
      SEL_RXCTL = 3'd2,
      SEL_RXBUF = 3'd3,
      SEL_RXLEN = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/hdlc_bus_hs.sv
module hdlc_bus_hs (
   input  logic clk,
   input  logic rst,
   input  logic req_i,
   input  logic retry_i,
   output logic accept_o,
   output logic ack_o,
   output logic rty_o
);
   logic ack_q, rty_q, idle;

   assign idle     = !ack_q && !rty_q;
   assign accept_o = req_i && idle && !retry_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_q <= 1'b0;
         rty_q <= 1'b0;
      end else begin
         ack_q <= accept_o;
         rty_q <= req_i && idle && retry_i;
      end
   end

   assign ack_o = ack_q;
   assign rty_o = rty_q;
endmodule

// File: rtl/hdlc_txbuf.sv
module hdlc_txbuf #(
   parameter int WORDS = 8,
   parameter int LANES = 4,
   localparam int DW    = LANES * 8,
   localparam int WI_W  = $clog2(WORDS),
   localparam int WC_W  = $clog2(WORDS + 1),
   localparam int LB    = $clog2(LANES),
   localparam int OP_W  = WI_W + LB,
   localparam int LEN_W = $clog2(WORDS * LANES + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_i,
   input  logic [DW-1:0]    word_i,
   input  logic             go_i,
   input  logic             done_i,
   input  logic             oct_rd_i,
   output logic             busy_o,
   output logic             ready_o,
   output logic             start_o,
   output logic [LEN_W-1:0] len_o,
   output logic [7:0]       oct_o
);
   logic [DW-1:0]   mem [WORDS];
   logic [WC_W-1:0] wcnt;
   logic [OP_W-1:0] optr;
   logic            busy, full;
   logic [DW-1:0]   cur_word;
   logic [7:0]      lane_v [LANES];

   assign full = (wcnt == WC_W'(WORDS));

   always_ff @(posedge clk) begin
      if (wr_i && !busy && !full)
         mem[wcnt[WI_W-1:0]] <= word_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wcnt    <= '0;
         optr    <= '0;
         busy    <= 1'b0;
         start_o <= 1'b0;
      end else begin
         start_o <= 1'b0;
         if (busy) begin
            if (oct_rd_i)
               optr <= optr + 1'b1;
            if (done_i) begin
               busy <= 1'b0;
               wcnt <= '0;
            end
         end else begin
            if (wr_i && !full)
               wcnt <= wcnt + 1'b1;
            else if (go_i && wcnt != '0) begin
               busy    <= 1'b1;
               start_o <= 1'b1;
               optr    <= '0;
            end
         end
      end
   end

   assign cur_word = mem[optr[OP_W-1:LB]];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_v[g] = cur_word[g*8 +: 8];
   end

   assign oct_o   = lane_v[optr[LB-1:0]];
   assign len_o   = LEN_W'(wcnt * LANES);
   assign busy_o  = busy;
   assign ready_o = !busy && !full;
endmodule

// File: rtl/hdlc_rxbuf.sv
module hdlc_rxbuf #(
   parameter int WORDS = 8,
   parameter int LANES = 4,
   localparam int DW    = LANES * 8,
   localparam int CAP   = WORDS * LANES,
   localparam int WI_W  = $clog2(WORDS),
   localparam int RP_W  = $clog2(WORDS + 1),
   localparam int LB    = $clog2(LANES),
   localparam int CNT_W = $clog2(CAP + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             oct_wr_i,
   input  logic [7:0]       oct_i,
   input  logic             end_i,
   input  logic             release_i,
   input  logic             rd_adv_i,
   output logic             ready_o,
   output logic [CNT_W-1:0] count_o,
   output logic [DW-1:0]    rd_word_o
);
   logic [DW-1:0]    mem [WORDS];
   logic [CNT_W-1:0] count;
   logic [RP_W-1:0]  rptr;
   logic             ready, full, take, rd_valid;
   logic [WI_W-1:0]  widx;
   logic [LB-1:0]    lane;
   logic [CNT_W:0]   sum, used;

   assign full = (count == CNT_W'(CAP));
   assign take = oct_wr_i && !ready && !full && !release_i;
   assign widx = count[LB +: WI_W];
   assign lane = count[LB-1:0];

   always_ff @(posedge clk) begin
      if (take) begin
         for (int l = 0; l < LANES; l++) begin
            if (lane == LB'(l))
               mem[widx][l*8 +: 8] <= oct_i;
            else if (lane == '0)
               mem[widx][l*8 +: 8] <= '0;
         end
      end
   end

   assign sum      = {1'b0, count} + (CNT_W+1)'(LANES - 1);
   assign used     = sum >> LB;
   assign rd_valid = ((CNT_W+1)'(rptr) < used);

   always_ff @(posedge clk) begin
      if (rst) begin
         ready <= 1'b0;
         count <= '0;
         rptr  <= '0;
      end else if (release_i) begin
         ready <= 1'b0;
         count <= '0;
         rptr  <= '0;
      end else begin
         if (take)
            count <= count + 1'b1;
         if (end_i && !ready)
            ready <= 1'b1;
         if (rd_adv_i && rd_valid)
            rptr <= rptr + 1'b1;
      end
   end

   assign rd_word_o = rd_valid ? mem[rptr[WI_W-1:0]] : '0;
   assign ready_o   = ready;
   assign count_o   = count;
endmodule

// File: rtl/hdlc_host_regs.sv
module hdlc_host_regs
   import hdlc_host_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int TX_WORDS = 8,
   parameter int RX_WORDS = 8,
   localparam int LANES = DATA_W / OCT_W,
   localparam int TXL_W = $clog2(TX_WORDS * LANES + 1),
   localparam int RXC_W = $clog2(RX_WORDS * LANES + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cyc_i,
   input  logic              stb_i,
   input  logic              we_i,
   input  logic [2:0]        adr_i,
   input  logic [DATA_W-1:0] dat_i,
   output logic [DATA_W-1:0] dat_o,
   output logic              ack_o,
   output logic              rty_o,
   output logic              tag0_o,
   output logic              tag1_o,
   output logic              tx_start_o,
   output logic [TXL_W-1:0]  tx_len_o,
   output logic [7:0]        tx_oct_o,
   input  logic              tx_oct_rd_i,
   input  logic              tx_done_i,
   input  logic              rx_oct_wr_i,
   input  logic [7:0]        rx_oct_i,
   input  logic              rx_end_i
);
   if (DATA_W % OCT_W != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power-of-two multiple of 8, at least 16");
   end
   if (TX_WORDS < 2 || (TX_WORDS & (TX_WORDS - 1)) != 0 ||
       RX_WORDS < 2 || (RX_WORDS & (RX_WORDS - 1)) != 0) begin : g_bad_depth
      $error("buffer depths must be powers of two, at least 2");
   end
   if (RXC_W > 8) begin : g_bad_size
      $error("receive frame size must fit in bits 7:0");
   end

   logic              accept, retry, tx_busy, tx_ready, rx_ready;
   logic              wr_txbuf, tx_go, rx_release, rx_adv;
   logic [RXC_W-1:0]  rx_count;
   logic [DATA_W-1:0] rx_word, rd_mux, dat_q;

   assign retry = we_i && (adr_i == SEL_TXBUF) && tx_busy;

   hdlc_bus_hs u_hs (
      .clk      (clk),
      .rst      (rst),
      .req_i    (cyc_i && stb_i),
      .retry_i  (retry),
      .accept_o (accept),
      .ack_o    (ack_o),
      .rty_o    (rty_o)
   );

   assign wr_txbuf   = accept && we_i && (adr_i == SEL_TXBUF);
   assign tx_go      = accept && we_i && (adr_i == SEL_TXCTL) && (dat_i[7:0] == TX_GO_CODE);
   assign rx_release = accept && !we_i && (adr_i == SEL_RXCTL);
   assign rx_adv     = accept && !we_i && (adr_i == SEL_RXBUF);

   hdlc_txbuf #(.WORDS(TX_WORDS), .LANES(LANES)) u_tx (
      .clk      (clk),
      .rst      (rst),
      .wr_i     (wr_txbuf),
      .word_i   (dat_i),
      .go_i     (tx_go),
      .done_i   (tx_done_i),
      .oct_rd_i (tx_oct_rd_i),
      .busy_o   (tx_busy),
      .ready_o  (tx_ready),
      .start_o  (tx_start_o),
      .len_o    (tx_len_o),
      .oct_o    (tx_oct_o)
   );

   hdlc_rxbuf #(.WORDS(RX_WORDS), .LANES(LANES)) u_rx (
      .clk       (clk),
      .rst       (rst),
      .oct_wr_i  (rx_oct_wr_i),
      .oct_i     (rx_oct_i),
      .end_i     (rx_end_i),
      .release_i (rx_release),
      .rd_adv_i  (rx_adv),
      .ready_o   (rx_ready),
      .count_o   (rx_count),
      .rd_word_o (rx_word)
   );

   always_comb begin
      rd_mux = '0;
      case (adr_i)
         SEL_TXCTL: rd_mux[1:0]       = {tx_ready, tx_busy};
         SEL_RXCTL: rd_mux[0]         = rx_ready;
         SEL_RXBUF: rd_mux            = rx_word;
         SEL_RXLEN: rd_mux[RXC_W-1:0] = rx_count;
         default:   rd_mux            = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         dat_q <= '0;
      else if (accept)
         dat_q <= we_i ? '0 : rd_mux;
   end

   assign dat_o  = dat_q;
   assign tag0_o = tx_ready;
   assign tag1_o = rx_ready;
endmodule

// File: rtl/hdlc_host_regs_chk.sv
module hdlc_host_regs_chk (
   input logic       clk,
   input logic       rst,
   input logic       cyc_i,
   input logic       stb_i,
   input logic       we_i,
   input logic [2:0] adr_i,
   input logic       ack_o,
   input logic       rty_o,
   input logic       tag0_o,
   input logic       tag1_o,
   input logic       tx_start_o,
   input logic       rx_end_i
);
   // R2
   a_r2_ack_rty_excl: assert property (@(posedge clk) disable iff (rst)
      !(ack_o && rty_o));
   // R2
   a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
      ack_o |-> $past(cyc_i && stb_i));
   // R2
   a_r2_ack_spacing: assert property (@(posedge clk) disable iff (rst)
      ack_o |=> !ack_o);
   // R4
   a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
      tx_start_o |=> !tx_start_o);
   // R4
   a_r4_start_drops_tag0: assert property (@(posedge clk) disable iff (rst)
      tx_start_o |-> !tag0_o);
   // R5
   a_r5_rty_source: assert property (@(posedge clk) disable iff (rst)
      rty_o |-> $past(cyc_i && stb_i && we_i && adr_i == 3'd1));
   // R7
   a_r7_end_sets_tag1: assert property (@(posedge clk) disable iff (rst)
      (rx_end_i && !tag1_o && !(cyc_i && stb_i && !we_i && adr_i == 3'd2)) |=> tag1_o);
   // R10
   a_r10_release_clears: assert property (@(posedge clk) disable iff (rst)
      (ack_o && $past(!we_i && adr_i == 3'd2)) |-> !tag1_o);
endmodule

bind hdlc_host_regs hdlc_host_regs_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .cyc_i      (cyc_i),
   .stb_i      (stb_i),
   .we_i       (we_i),
   .adr_i      (adr_i),
   .ack_o      (ack_o),
   .rty_o      (rty_o),
   .tag0_o     (tag0_o),
   .tag1_o     (tag1_o),
   .tx_start_o (tx_start_o),
   .rx_end_i   (rx_end_i)
);

// File: tb/hdlc_host_regs_test.sv
module hdlc_host_regs_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cyc_i = 1'b0, stb_i = 1'b0, we_i = 1'b0;
   logic [2:0]  adr_i = '0;
   logic [31:0] dat_i = '0;
   logic [31:0] dat_o;
   logic        ack_o, rty_o, tag0_o, tag1_o, tx_start_o;
   logic [5:0]  tx_len_o;
   logic [7:0]  tx_oct_o;
   logic        tx_oct_rd_i = 1'b0, tx_done_i = 1'b0;
   logic        rx_oct_wr_i = 1'b0, rx_end_i = 1'b0;
   logic [7:0]  rx_oct_i = '0;

   int checks = 0;
   int errors = 0;
   logic [31:0] sb_exp [$];
   string       sb_tag [$];
   logic [7:0]  tx_exp [$];
   logic        last_start;
   logic [5:0]  last_len;
   logic        got_rty;

   always #5 clk = ~clk;

   hdlc_host_regs uut (
      .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
      .adr_i(adr_i), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o), .rty_o(rty_o),
      .tag0_o(tag0_o), .tag1_o(tag1_o), .tx_start_o(tx_start_o), .tx_len_o(tx_len_o),
      .tx_oct_o(tx_oct_o), .tx_oct_rd_i(tx_oct_rd_i), .tx_done_i(tx_done_i),
      .rx_oct_wr_i(rx_oct_wr_i), .rx_oct_i(rx_oct_i), .rx_end_i(rx_end_i)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every read acknowledge
   always @(negedge clk) begin
      if (!rst && ack_o && cyc_i && stb_i && !we_i) begin
         if (sb_exp.size() == 0)
            check(1'b0, "R2 unexpected read ack", dat_o, 32'h0);
         else begin
            logic [31:0] e;
            string t;
            e = sb_exp.pop_front();
            t = sb_tag.pop_front();
            check(dat_o == e, t, dat_o, e);
         end
      end
   end

   task automatic expect_rd(input logic [31:0] e, input string t);
      sb_exp.push_back(e);
      sb_tag.push_back(t);
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      cyc_i = 1; stb_i = 1; we_i = 1; adr_i = a; dat_i = d;
      forever begin
         @(negedge clk);
         if (ack_o || rty_o) begin
            got_rty    = rty_o;
            last_start = tx_start_o;
            last_len   = tx_len_o;
            break;
         end
      end
      #1; cyc_i = 0; stb_i = 0; we_i = 0;
   endtask

   task automatic bus_rd(input logic [2:0] a, input logic [31:0] e, input string t);
      expect_rd(e, t);
      @(negedge clk); #1;
      cyc_i = 1; stb_i = 1; we_i = 0; adr_i = a;
      forever begin
         @(negedge clk);
         if (ack_o) break;
      end
      #1; cyc_i = 0; stb_i = 0;
   endtask

   // burst read of n words already pushed to the scoreboard; checks ack spacing
   task automatic rd_burst(input int n);
      int acks = 0;
      int cyc_n = 0;
      int last = -1;
      @(negedge clk); #1;
      cyc_i = 1; stb_i = 1; we_i = 0; adr_i = 3'd3;
      while (acks < n) begin
         @(negedge clk);
         cyc_n++;
         if (ack_o) begin
            if (last >= 0)
               check(cyc_n - last == 2, "R2 burst ack spacing", 32'(cyc_n - last), 32'd2);
            last = cyc_n;
            acks++;
         end
      end
      #1; cyc_i = 0; stb_i = 0;
   endtask

   function automatic logic [31:0] rx_word(input logic [7:0] seed, input int n, input int w);
      logic [31:0] r = '0;
      for (int l = 0; l < 4; l++)
         if (w * 4 + l < n) r[l*8 +: 8] = seed + 8'(w * 4 + l);
      return r;
   endfunction

   task automatic rx_frame(input logic [7:0] seed, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); #1;
         rx_oct_wr_i = 1; rx_oct_i = seed + 8'(k);
      end
      @(negedge clk); #1;
      rx_oct_wr_i = 0; rx_end_i = 1;
      @(negedge clk); #1;
      rx_end_i = 0;
   endtask

   task automatic tx_word(input logic [31:0] w);
      bus_wr(3'd1, w);
      check(got_rty == 0, "R3 tx buffer write acked", 32'(got_rty), 32'd0);
      for (int l = 0; l < 4; l++) tx_exp.push_back(w[l*8 +: 8]);
   endtask

   task automatic tx_drain(input int n);
      for (int k = 0; k < n; k++) begin
         logic [7:0] e;
         @(negedge clk);
         e = tx_exp.pop_front();
         check(tx_oct_o == e, "R3 tx octet", 32'(tx_oct_o), 32'(e));
         #1; tx_oct_rd_i = (k != n - 1);
      end
      @(negedge clk); #1;
      tx_oct_rd_i = 0; tx_done_i = 1;
      @(negedge clk); #1;
      tx_done_i = 0;
      @(negedge clk);
      check(tag0_o == 1, "R6 tag0 after done", 32'(tag0_o), 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1; rst = 0;
      @(negedge clk);
      check(ack_o == 0 && rty_o == 0 && tx_start_o == 0, "R1 reset handshake", {ack_o, rty_o, tx_start_o}, 0);
      check(tag0_o == 1 && tag1_o == 0, "R1 reset tags", {tag0_o, tag1_o}, 32'b10);
      bus_rd(3'd4, 32'd0, "R1 frame size after reset");

      bus_rd(3'd0, 32'd2, "R12 tx control idle");
      bus_rd(3'd6, 32'd0, "R12 unused address reads 0");
      bus_wr(3'd5, 32'hFFFF_FFFF);
      bus_rd(3'd5, 32'd0, "R12 unused address write ignored");

      // receive: 10 octets
      rx_frame(8'h00, 10);
      @(negedge clk);
      check(tag1_o == 1, "R7 tag1 after frame end", 32'(tag1_o), 32'd1);
      bus_rd(3'd4, 32'd10, "R8 frame size");
      for (int w = 0; w < 4; w++) expect_rd(rx_word(8'h00, 10, w), "R7 R9 burst word");
      rd_burst(4);
      bus_rd(3'd3, 32'd0, "R9 read past frame");

      // frame arriving while previous is pending is ignored
      rx_frame(8'h80, 3);
      bus_rd(3'd4, 32'd10, "R11 size unchanged while ready");

      bus_rd(3'd2, 32'd1, "R10 rx control ready bit");
      @(negedge clk);
      check(tag1_o == 0, "R10 tag1 cleared", 32'(tag1_o), 32'd0);
      bus_rd(3'd4, 32'd0, "R10 size reset");

      rx_frame(8'h40, 5);
      expect_rd(rx_word(8'h40, 5, 0), "R10 pointer rewound");
      expect_rd(rx_word(8'h40, 5, 1), "R7 partial last word");
      rd_burst(2);
      bus_rd(3'd2, 32'd1, "R10 release second frame");

      // transmit
      tx_word(32'h0302_0100);
      tx_word(32'hA7B6_C5D4);
      tx_word(32'h1122_3344);
      bus_wr(3'd0, 32'h0000_0021);
      check(last_start == 0, "R4 wrong code no start", 32'(last_start), 32'd0);
      bus_rd(3'd0, 32'd2, "R4 still idle after wrong code");
      bus_wr(3'd0, 32'h0000_0022);
      check(last_start == 1, "R4 start pulse", 32'(last_start), 32'd1);
      check(last_len == 6'd12, "R4 tx length", 32'(last_len), 32'd12);
      @(negedge clk);
      check(tx_start_o == 0 && tag0_o == 0, "R4 pulse ends, tag0 low", {tx_start_o, tag0_o}, 0);
      bus_rd(3'd0, 32'd1, "R12 tx busy readback");
      bus_wr(3'd1, 32'hDEAD_BEEF);
      check(got_rty == 1, "R5 write while busy retried", 32'(got_rty), 32'd1);
      @(negedge clk);
      check(tx_len_o == 6'd12, "R5 length unchanged", 32'(tx_len_o), 32'd12);
      tx_drain(12);

      // fill the buffer
      for (int w = 0; w < 8; w++) tx_word(32'h1010_1010 * 32'(w) + 32'h0403_0201);
      check(tag0_o == 0, "R6 tag0 low when full", 32'(tag0_o), 32'd0);
      bus_wr(3'd1, 32'hFFFF_FFFF);
      check(got_rty == 0, "R6 write to full buffer acked", 32'(got_rty), 32'd0);
      bus_wr(3'd0, 32'h22);
      check(last_len == 6'd32, "R6 extra write dropped", 32'(last_len), 32'd32);
      tx_drain(32);

      bus_wr(3'd0, 32'h22);
      check(last_start == 0, "R4 empty buffer no start", 32'(last_start), 32'd0);
      @(negedge clk);
      check(tag0_o == 1, "R4 empty start leaves tag0", 32'(tag0_o), 32'd1);

      repeat (3) @(negedge clk);
      check(sb_exp.size() == 0, "R2 all reads answered", 32'(sb_exp.size()), 32'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule